// File: doc/BRIEF.md
# Key-Locked Register Write Gate

This block stands between a simple register bus and a bank of configuration registers. It qualifies every write that the bank sees. The bank is writable only while two key registers each hold their own 32-bit magic word. Writing any other value into either key closes the bank again at once. Addresses at or above a protection limit are outside the guarded range, and writes to them always go through.

The gate contains the two key registers and their address decode. It exposes the current lock state and forwards a single write-enable qualifier to the bank. Reads are never gated. A read of a key address returns the key contents, and a read of any other address returns the bank's own read data unchanged. Software normally opens the bank by writing the first key and then the second, does its configuration writes, and clears a key to close the bank. The gate itself looks only at what the keys hold, not at the order in which they were written.

The key offsets (0x6C and 0x70), the magic words and the protection limit are parameters.

Top module: `regbank_key_gate`

## Requirements
- R1: After a synchronous active-low reset, `locked` is 1 and both key addresses read as 0x00000000.
- R2: A write to key 0 (address 0x6C) or key 1 (address 0x70) stores the full 32-bit data. A read of that address returns the stored value in the same cycle.
- R3: `locked` is 0 only while key 0 holds 0x83E70B13 and key 1 holds 0x95A4F1E0. It falls in the cycle after the write that completes this pair, and it does not change in a cycle without a write.
- R4: A write of any other value (zero included) to either key sets `locked` to 1 in the following cycle.
- R5: Unlocking does not depend on write order. Writing key 1 before key 0 opens the bank just as writing key 0 before key 1 does.
- R6: While `locked` is 1, a write to a non-key address below the protection limit (0xA0) leaves `bank_we` at 0, and no error is signalled.
- R7: While `locked` is 0, a write to a non-key address below the protection limit raises `bank_we` in the same cycle as `bus_wr`.
- R8: For any non-key address, `bus_rdata` equals `bank_rdata` in the same cycle, whatever the lock state.
- R9: A write to an address at or above the protection limit raises `bank_we` even while `locked` is 1.
- R10: A write to a key address never raises `bank_we`.
- R11: The magic words are bound to their keys. If key 0 holds key 1's word and key 1 holds key 0's word, the bank stays locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data: key contents or bank data |
| bank_rdata | input | 32 | Read data from the guarded bank |
| bank_we | output | 1 | Qualified write enable towards the bank |
| locked | output | 1 | 1 while the bank is write-protected |

## Verification
Guarded writes are tried in both lock states, so a gate stuck open or stuck closed shows up. Unguarded writes above the limit are tried while the bank is locked, which separates the range decode from the lock. Unlock is attempted in both key orders and with the two magic words swapped between keys, which exposes a lock that checks only one key or matches a word against the wrong key. Relock is driven with zero and with an arbitrary nonzero word, and read pass-through is checked at key and non-key addresses in both states.

// File: rtl/kg_pkg.sv
// Shared constants for the key-locked write gate.
// Assumes exactly two keys; widths are fixed by the bus.
package kg_pkg;
    localparam int KG_NUM_KEYS = 2;
    localparam int KG_ADDR_W   = 8;
    localparam int KG_DATA_W   = 32;
    typedef logic [KG_ADDR_W-1:0] kg_addr_t;
    typedef logic [KG_DATA_W-1:0] kg_data_t;
endpackage

// File: rtl/kg_decode.sv
// Address decode for the write gate: flags which key (if any) an address
// selects and whether the address lies in the guarded range.
// Assumes key addresses are distinct and below PROT_LIMIT.
module kg_decode #(
    parameter int NUM_KEYS = kg_pkg::KG_NUM_KEYS,
    parameter int ADDR_W   = kg_pkg::KG_ADDR_W,
    parameter logic [NUM_KEYS-1:0][ADDR_W-1:0] KEY_ADDR = '0,
    parameter logic [ADDR_W-1:0] PROT_LIMIT = '0
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_KEYS-1:0] key_hit,
    output logic                guarded
);
    // One comparator per key address.
    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_cmp
        assign key_hit[k] = (addr == KEY_ADDR[k]);
    end

    // Guarded means below the limit and not a key slot.
    always_comb begin
        guarded = (addr < PROT_LIMIT) && (key_hit == '0);
    end
endmodule

// File: rtl/kg_key_slot.sv
// One key register: stores the last written word and reports whether it
// equals the unlock word for this slot. Clears to zero on reset.
module kg_key_slot #(
    parameter int DATA_W = kg_pkg::KG_DATA_W,
    parameter logic [DATA_W-1:0] OPEN_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value,
    output logic              match
);
    // Key storage: synchronous reset, load on a write to this slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (wr_en) begin
            value <= wdata;
        end
    end

    // Match flag against this slot's unlock word.
    always_comb begin
        match = (value == OPEN_WORD);
    end
endmodule

// File: rtl/regbank_key_gate.sv
// Write gate for a register bank. Two key registers must both hold their
// unlock words before guarded writes reach the bank; any other key value
// closes it. Reads are passed through untouched. Assumes single-cycle
// write strobes and a combinational bank read path.
module regbank_key_gate #(
    parameter int ADDR_W = kg_pkg::KG_ADDR_W,
    parameter int DATA_W = kg_pkg::KG_DATA_W,
    parameter logic [ADDR_W-1:0] KEY0_ADDR  = 8'h6C,
    parameter logic [ADDR_W-1:0] KEY1_ADDR  = 8'h70,
    parameter logic [DATA_W-1:0] KEY0_WORD  = 32'h83E7_0B13,
    parameter logic [DATA_W-1:0] KEY1_WORD  = 32'h95A4_F1E0,
    parameter logic [ADDR_W-1:0] PROT_LIMIT = 8'hA0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] bank_rdata,
    output logic              bank_we,
    output logic              locked
);
    localparam int NUM_KEYS = kg_pkg::KG_NUM_KEYS;
    localparam logic [NUM_KEYS-1:0][ADDR_W-1:0] KEY_ADDRS = {KEY1_ADDR, KEY0_ADDR};
    localparam logic [NUM_KEYS-1:0][DATA_W-1:0] KEY_WORDS = {KEY1_WORD, KEY0_WORD};

    logic [NUM_KEYS-1:0]             key_hit;
    logic [NUM_KEYS-1:0]             key_match;
    logic [NUM_KEYS-1:0][DATA_W-1:0] key_value;
    logic                            guarded;

    kg_decode #(
        .NUM_KEYS   (NUM_KEYS),
        .ADDR_W     (ADDR_W),
        .KEY_ADDR   (KEY_ADDRS),
        .PROT_LIMIT (PROT_LIMIT)
    ) u_decode (
        .addr    (bus_addr),
        .key_hit (key_hit),
        .guarded (guarded)
    );

    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
        kg_key_slot #(
            .DATA_W    (DATA_W),
            .OPEN_WORD (KEY_WORDS[k])
        ) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (bus_wr && key_hit[k]),
            .wdata (bus_wdata),
            .value (key_value[k]),
            .match (key_match[k])
        );
    end

    // Lock state: open only when every key matches its word.
    always_comb begin
        locked = !(&key_match);
    end

    // Write qualifier: guarded range needs the bank open, keys never pass.
    always_comb begin
        if (!bus_wr || key_hit != '0) begin
            bank_we = 1'b0;
        end else if (guarded) begin
            bank_we = !locked;
        end else begin
            bank_we = 1'b1;
        end
    end

    // Read mux: key contents at key addresses, bank data elsewhere.
    always_comb begin
        bus_rdata = bank_rdata;
        for (int k = 0; k < NUM_KEYS; k++) begin
            if (key_hit[k]) begin
                bus_rdata = key_value[k];
            end
        end
    end
endmodule

// File: rtl/regbank_key_gate_chk.sv
// Property checker for regbank_key_gate, attached with bind.
// Recomputes the address decode from parameters and watches the ports.
module regbank_key_gate_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] KEY0_ADDR  = 8'h6C,
    parameter logic [ADDR_W-1:0] KEY1_ADDR  = 8'h70,
    parameter logic [ADDR_W-1:0] PROT_LIMIT = 8'hA0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] bank_rdata,
    input logic              bank_we,
    input logic              locked
);
    logic at_key;
    assign at_key = (bus_addr == KEY0_ADDR) || (bus_addr == KEY1_ADDR);

    AST_IDLE_LOCK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(locked)); // R3
    AST_BAD_KEY_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_key && bus_wdata == '0) |=> locked); // R4
    AST_LOCKED_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !at_key && bus_addr < PROT_LIMIT && locked) |-> !bank_we); // R6
    AST_READ_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !at_key |-> (bus_rdata == bank_rdata)); // R8
    AST_OPEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr >= PROT_LIMIT) |-> bank_we); // R9
    AST_KEY_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_key) |-> !bank_we); // R10
endmodule

bind regbank_key_gate regbank_key_gate_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .KEY0_ADDR  (KEY0_ADDR),
    .KEY1_ADDR  (KEY1_ADDR),
    .PROT_LIMIT (PROT_LIMIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bank_rdata (bank_rdata),
    .bank_we    (bank_we),
    .locked     (locked)
);

// File: tb/test_regbank_key_gate.sv
`timescale 1ns/1ps
module test_regbank_key_gate;
    localparam logic [7:0]  K0A = 8'h6C;
    localparam logic [7:0]  K1A = 8'h70;
    localparam logic [31:0] K0W = 32'h83E7_0B13;
    localparam logic [31:0] K1W = 32'h95A4_F1E0;
    localparam logic [7:0]  LIM = 8'hA0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] bank_rdata = '0;
    logic        bank_we;
    logic        locked;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        string       tag;
        logic        we;
        logic        lk;
        logic [31:0] rd;
    } exp_t;
    exp_t sb[$];

    logic [31:0] m_k0 = '0;
    logic [31:0] m_k1 = '0;

    always #2 clk = ~clk;

    regbank_key_gate i_regbank_key_gate (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bank_rdata(bank_rdata),
        .bank_we(bank_we), .locked(locked)
    );

    // Driver: applies one access and queues what the ports must show.
    task automatic op(input bit wr, input logic [7:0] a, input logic [31:0] d, input string tag);
        exp_t e;
        logic is_key;
        logic lk;
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        bank_rdata = {8'hB5, a, ~a, 8'h3C};
        is_key = (a == K0A) || (a == K1A);
        lk = !(m_k0 == K0W && m_k1 == K1W);
        e.tag = tag;
        e.lk  = lk;
        e.we  = wr && !is_key && ((a >= LIM) || !lk);
        e.rd  = (a == K0A) ? m_k0 : (a == K1A) ? m_k1 : bank_rdata;
        sb.push_back(e);
        if (wr && a == K0A) m_k0 = d;
        if (wr && a == K1A) m_k1 = d;
        @(posedge clk);
        #0.5 bus_wr = 1'b0;
    endtask

    // Monitor: compares ports against the queued expectations.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_checks++;
                if (bank_we !== e.we || locked !== e.lk || bus_rdata !== e.rd) begin
                    n_fail++;
                    $display("FAIL %s: we=%0b lk=%0b rd=%h expected we=%0b lk=%0b rd=%h",
                             e.tag, bank_we, locked, bus_rdata, e.we, e.lk, e.rd);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #100000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #0.5 rst_n = 1'b1;
        op(0, K0A, '0, "R1 key0 zero after reset");
        op(0, K1A, '0, "R1 key1 zero, locked");
        op(1, 8'h00, 32'h1111, "R6 guarded write dropped while locked");
        op(0, 8'h10, '0, "R8 read passes while locked");
        op(1, 8'hA0, 32'h2222, "R9 write at limit passes while locked");
        op(1, 8'hF8, 32'h2223, "R9 high write passes while locked");
        op(1, K0A, K0W, "R10 key0 write no bank_we");
        op(0, K0A, '0, "R2 key0 readback, still locked");
        op(1, K1A, K1W, "R10 key1 write no bank_we");
        op(0, K1A, '0, "R3 unlocked after second key");
        op(1, 8'h04, 32'h3333, "R7 guarded write passes while unlocked");
        op(0, 8'h44, '0, "R8 read passes while unlocked");
        op(0, 8'h20, '0, "R3 no write keeps lock state");
        op(1, K1A, 32'h0, "R4 zero to key1");
        op(1, 8'h08, 32'h4444, "R4 relocked, guarded write dropped");
        op(1, K0A, 32'h0, "R5 clear key0");
        op(1, K1A, K1W, "R5 key1 first");
        op(0, 8'h0C, '0, "R5 still locked with key1 only");
        op(1, K0A, K0W, "R5 key0 second");
        op(1, 8'h30, 32'h5555, "R5 unlocked in reverse order");
        op(1, K0A, 32'h1234_5678, "R4 nonzero wrong word to key0");
        op(1, 8'h34, 32'h6666, "R4 locked after wrong word");
        op(1, K0A, K1W, "R11 key0 gets key1 word");
        op(1, K1A, K0W, "R11 key1 gets key0 word");
        op(1, 8'h38, 32'h7777, "R11 swapped words stay locked");
        op(0, K1A, '0, "R2 key1 readback");
        @(negedge clk);
        @(negedge clk);
        #2;
        done = 1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule